// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between a store producer and a bus controller and holds outgoing stores until the bus takes them. It has eight slots, and each slot covers one 16-byte aligned line. A slot keeps a byte-enable mask and the line's data. A store arrives as a line address, a full line of data and a byte mask. Two attributes come with it: whether its region allows merging, and whether it is unbuffered (non-cacheable and non-bufferable). A global coalesce enable applies to all stores. The buffer is always on. Slots leave through a valid/ready handshake in the order they were allocated.

When coalescing is enabled globally and the region allows it, a store can fold into an existing slot for the same line. That slot must be the youngest live slot for that line, and it must not be the one currently offered to the bus. Merged bytes overwrite older ones and the masks are OR-ed. Because of this, a later store can reach memory before earlier stores to other lines. When coalescing is off, every store takes its own slot and memory sees program order.

An unbuffered store waits until the buffer is empty. Once accepted, it holds the producer off until the bus has taken it. A drain pulse stops acceptance until every slot has left.

Top module: `coalesce_wbuf`

## Requirements
- R1: After reset the buffer is empty: `bus_valid` is 0 and `st_ready` is 1 for an idle buffered store.
- R2: With `coalesce_en`=0, every accepted store allocates its own slot. Slots leave in acceptance order, even for the same line with `st_merge_ok`=1.
- R3: With `coalesce_en`=1 and `st_merge_ok`=1, a store to the line of the youngest live slot for that line merges into that slot, provided the slot is not the head. The slot's mask becomes the OR of the two masks, byte i (data bits 8i+7:8i) takes the new value where the new mask bit i is 1, and no new slot is used.
- R4: With `coalesce_en`=1 but `st_merge_ok`=0, a store never merges and always allocates.
- R5: The head slot, which is the one offered on the bus, is never merged into. A store whose youngest matching slot is the head allocates a new slot.
- R6: With all eight slots occupied, `st_ready` is 0 for a store that cannot merge. A store that can merge is still accepted.
- R7: A store with `st_unbuf`=1 is accepted only when the buffer is empty. After that, `st_ready` stays 0 until the bus has taken that store.
- R8: After a one-cycle `drain_req` pulse, `st_ready` stays 0 until the buffer has emptied.
- R9: `bus_valid` is 1 whenever a slot is held. While `bus_valid`=1 and `bus_ready`=0, `bus_line`, `bus_be` and `bus_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coalesce_en | input | 1 | Global merge enable |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted on this edge when high with `st_valid` |
| st_line | input | ADDR_W-log2(LINE_B) | Line address (byte address without offset bits) |
| st_data | input | LINE_B*8 | Store data, byte i in bits 8i+7:8i |
| st_be | input | LINE_B | Byte mask for the line |
| st_merge_ok | input | 1 | Region allows merging |
| st_unbuf | input | 1 | Region is non-cacheable and non-bufferable |
| drain_req | input | 1 | Drain pulse |
| bus_valid | output | 1 | Head slot offered to the bus |
| bus_ready | input | 1 | Bus takes the head slot |
| bus_line | output | ADDR_W-log2(LINE_B) | Head slot line address |
| bus_data | output | LINE_B*8 | Head slot data |
| bus_be | output | LINE_B | Head slot byte mask |

## Verification
The merge path is tried with several store patterns while the bus is stalled. These are: a repeat to a line held by a non-head slot, which should merge; a repeat whose only match is the head, which should allocate; two stores to the same line with the region attribute cleared; and two stores to the same line with the global enable cleared. The drained sequence separates correct merging from merging into the wrong copy, and it also separates merging from plain allocation by mask, data and order. A ninth store to a full buffer tells the full stall apart from the merge-while-full path. Directed sequences check that an unbuffered store waits for the buffer to empty and then holds the producer off. They also check that a drain pulse stops acceptance until the last slot has left.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
   typedef enum logic [1:0] {
      SLOT_HOLD  = 2'd0,
      SLOT_ALLOC = 2'd1,
      SLOT_MERGE = 2'd2
   } slot_op_e;
endpackage

// File: rtl/cwb_entry.sv
module cwb_entry
   import cwb_pkg::*;
#(
   parameter int LINE_B = 16,
   parameter int TAG_W  = 28
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  slot_op_e              op_i,
   input  logic [TAG_W-1:0]      tag_i,
   input  logic [LINE_B*8-1:0]   data_i,
   input  logic [LINE_B-1:0]     be_i,
   output logic [TAG_W-1:0]      tag_o,
   output logic [LINE_B*8-1:0]   data_o,
   output logic [LINE_B-1:0]     be_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_o  <= '0;
         data_o <= '0;
         be_o   <= '0;
      end else begin
         case (op_i)
            SLOT_ALLOC: begin
               tag_o  <= tag_i;
               data_o <= data_i;
               be_o   <= be_i;
            end
            SLOT_MERGE: begin
               be_o <= be_o | be_i;
               for (int b = 0; b < LINE_B; b++) begin
                  if (be_i[b]) data_o[b*8 +: 8] <= data_i[b*8 +: 8];
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cwb_match.sv
module cwb_match #(
   parameter int N_ENT    = 8,
   parameter int TAG_W    = 28,
   parameter bit MERGE_EN = 1'b1,
   localparam int PTR_W   = $clog2(N_ENT),
   localparam int CNT_W   = $clog2(N_ENT + 1)
) (
   input  logic [TAG_W-1:0] tags_i [N_ENT],
   input  logic [PTR_W-1:0] head_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [TAG_W-1:0] req_tag_i,
   output logic             hit_o,
   output logic [PTR_W-1:0] hit_idx_o
);
   generate
      if (MERGE_EN) begin : g_search
         logic             found;
         logic             young_is_head;
         logic [PTR_W-1:0] young_idx;
         always_comb begin
            found         = 1'b0;
            young_is_head = 1'b0;
            young_idx     = '0;
            for (int k = 0; k < N_ENT; k++) begin
               logic [PTR_W-1:0] idx;
               idx = head_i + PTR_W'(k);
               if (k < int'(count_i) && tags_i[idx] == req_tag_i) begin
                  found         = 1'b1;
                  young_idx     = idx;
                  young_is_head = (k == 0);
               end
            end
         end
         assign hit_o     = found & ~young_is_head;
         assign hit_idx_o = young_idx;
      end else begin : g_nosearch
         assign hit_o     = 1'b0;
         assign hit_idx_o = '0;
      end
   endgenerate
endmodule

// File: rtl/coalesce_wbuf.sv
module coalesce_wbuf
   import cwb_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LINE_B   = 16,
   parameter int N_ENT    = 8,
   parameter bit MERGE_EN = 1'b1,
   localparam int OFS_W   = $clog2(LINE_B),
   localparam int TAG_W   = ADDR_W - OFS_W,
   localparam int DATA_W  = LINE_B * 8,
   localparam int PTR_W   = $clog2(N_ENT),
   localparam int CNT_W   = $clog2(N_ENT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              coalesce_en,
   input  logic              st_valid,
   output logic              st_ready,
   input  logic [TAG_W-1:0]  st_line,
   input  logic [DATA_W-1:0] st_data,
   input  logic [LINE_B-1:0] st_be,
   input  logic              st_merge_ok,
   input  logic              st_unbuf,
   input  logic              drain_req,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [TAG_W-1:0]  bus_line,
   output logic [DATA_W-1:0] bus_data,
   output logic [LINE_B-1:0] bus_be
);
   generate
      if (N_ENT < 2 || (N_ENT & (N_ENT - 1)) != 0) begin : g_bad_depth
         $error("coalesce_wbuf: N_ENT must be a power of two >= 2");
      end
      if (LINE_B < 2 || (LINE_B & (LINE_B - 1)) != 0) begin : g_bad_line
         $error("coalesce_wbuf: LINE_B must be a power of two >= 2");
      end
      if (ADDR_W <= OFS_W) begin : g_bad_addr
         $error("coalesce_wbuf: ADDR_W too small for LINE_B");
      end
   endgenerate

   logic [PTR_W-1:0]  head_q, tail_q;
   logic [CNT_W-1:0]  count_q;
   logic              ub_pend_q, drain_q;

   logic [TAG_W-1:0]  tag_arr  [N_ENT];
   logic [DATA_W-1:0] data_arr [N_ENT];
   logic [LINE_B-1:0] be_arr   [N_ENT];

   logic              hit;
   logic [PTR_W-1:0]  hit_idx;
   logic              empty, full, may_merge, take_merge, blocked;
   logic              acc, do_alloc, do_merge, pop;

   cwb_match #(
      .N_ENT   (N_ENT),
      .TAG_W   (TAG_W),
      .MERGE_EN(MERGE_EN)
   ) u_match (
      .tags_i   (tag_arr),
      .head_i   (head_q),
      .count_i  (count_q),
      .req_tag_i(st_line),
      .hit_o    (hit),
      .hit_idx_o(hit_idx)
   );

   assign empty      = (count_q == '0);
   assign full       = (count_q == CNT_W'(N_ENT));
   assign may_merge  = coalesce_en & st_merge_ok & ~st_unbuf;
   assign take_merge = may_merge & hit;
   assign blocked    = drain_q | drain_req | ub_pend_q;
   assign st_ready   = ~blocked & (st_unbuf ? empty : (take_merge | ~full));
   assign acc        = st_valid & st_ready;
   assign do_merge   = acc & take_merge;
   assign do_alloc   = acc & ~take_merge;

   assign bus_valid  = ~empty;
   assign pop        = bus_valid & bus_ready;
   assign bus_line   = tag_arr[head_q];
   assign bus_data   = data_arr[head_q];
   assign bus_be     = be_arr[head_q];

   generate
      for (genvar i = 0; i < N_ENT; i++) begin : g_slot
         slot_op_e op;
         always_comb begin
            if (do_alloc && tail_q == PTR_W'(i))      op = SLOT_ALLOC;
            else if (do_merge && hit_idx == PTR_W'(i)) op = SLOT_MERGE;
            else                                       op = SLOT_HOLD;
         end
         cwb_entry #(
            .LINE_B(LINE_B),
            .TAG_W (TAG_W)
         ) u_ent (
            .clk   (clk),
            .rst_n (rst_n),
            .op_i  (op),
            .tag_i (st_line),
            .data_i(st_data),
            .be_i  (st_be),
            .tag_o (tag_arr[i]),
            .data_o(data_arr[i]),
            .be_o  (be_arr[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q    <= '0;
         tail_q    <= '0;
         count_q   <= '0;
         ub_pend_q <= 1'b0;
         drain_q   <= 1'b0;
      end else begin
         if (do_alloc) tail_q <= tail_q + 1'b1;
         if (pop)      head_q <= head_q + 1'b1;
         count_q <= count_q + CNT_W'(do_alloc) - CNT_W'(pop);
         if (acc && st_unbuf) ub_pend_q <= 1'b1;
         else if (pop)        ub_pend_q <= 1'b0;
         if (drain_req)       drain_q <= 1'b1;
         else if (empty)      drain_q <= 1'b0;
      end
   end
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
   parameter int N_ENT  = 8,
   parameter int TAG_W  = 28,
   parameter int LINE_B = 16,
   parameter int DATA_W = 128,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              coalesce_en,
   input logic              st_valid,
   input logic              st_ready,
   input logic              st_unbuf,
   input logic              bus_valid,
   input logic              bus_ready,
   input logic [TAG_W-1:0]  bus_line,
   input logic [DATA_W-1:0] bus_data,
   input logic [LINE_B-1:0] bus_be,
   input logic [CNT_W-1:0]  count_q,
   input logic              ub_pend_q,
   input logic              drain_q
);
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(N_ENT));

   assert_head_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_line) &&
                                     $stable(bus_be) && $stable(bus_data)));

   assert_unbuf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ub_pend_q |-> !st_ready);

   assert_unbuf_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && st_unbuf) |-> (count_q == '0));

   assert_drain_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      drain_q |-> !st_ready);

   assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_ready && !coalesce_en && !(bus_valid && bus_ready))
         |=> (count_q == $past(count_q) + 1'b1));
endmodule

bind coalesce_wbuf cwb_checker #(
   .N_ENT (N_ENT),
   .TAG_W (TAG_W),
   .LINE_B(LINE_B),
   .DATA_W(DATA_W),
   .CNT_W (CNT_W)
) u_cwb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .coalesce_en(coalesce_en),
   .st_valid   (st_valid),
   .st_ready   (st_ready),
   .st_unbuf   (st_unbuf),
   .bus_valid  (bus_valid),
   .bus_ready  (bus_ready),
   .bus_line   (bus_line),
   .bus_data   (bus_data),
   .bus_be     (bus_be),
   .count_q    (count_q),
   .ub_pend_q  (ub_pend_q),
   .drain_q    (drain_q)
);

// File: tb/sim_coalesce_wbuf.sv
`timescale 1ns/1ps
module sim_coalesce_wbuf;
   localparam int TAG_W  = 28;
   localparam int LINE_B = 16;
   localparam int DATA_W = 128;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              coalesce_en = 1'b0;
   logic              st_valid = 1'b0;
   logic              st_ready;
   logic [TAG_W-1:0]  st_line = '0;
   logic [DATA_W-1:0] st_data = '0;
   logic [LINE_B-1:0] st_be = '0;
   logic              st_merge_ok = 1'b0;
   logic              st_unbuf = 1'b0;
   logic              drain_req = 1'b0;
   logic              bus_valid;
   logic              bus_ready = 1'b0;
   logic [TAG_W-1:0]  bus_line;
   logic [DATA_W-1:0] bus_data;
   logic [LINE_B-1:0] bus_be;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   coalesce_wbuf u0 (
      .clk(clk), .rst_n(rst_n), .coalesce_en(coalesce_en),
      .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
      .st_data(st_data), .st_be(st_be), .st_merge_ok(st_merge_ok),
      .st_unbuf(st_unbuf), .drain_req(drain_req), .bus_valid(bus_valid),
      .bus_ready(bus_ready), .bus_line(bus_line), .bus_data(bus_data),
      .bus_be(bus_be)
   );

   // {coalesce_en, merge_ok, line[7:0], be[15:0], fill byte[7:0]}
   localparam logic [33:0] ST_TAB [0:10] = '{
      {1'b1, 1'b1, 8'h10, 16'h000F, 8'h11},
      {1'b1, 1'b1, 8'h20, 16'h00F0, 8'h22},
      {1'b1, 1'b1, 8'h10, 16'h0F00, 8'h33},
      {1'b1, 1'b1, 8'h20, 16'h0030, 8'h44},
      {1'b1, 1'b0, 8'h30, 16'h0001, 8'h55},
      {1'b1, 1'b0, 8'h30, 16'h0002, 8'h66},
      {1'b1, 1'b1, 8'h10, 16'hF000, 8'h77},
      {1'b1, 1'b1, 8'h40, 16'h0001, 8'h88},
      {1'b0, 1'b1, 8'h40, 16'h0001, 8'h99},
      {1'b1, 1'b1, 8'h50, 16'h0001, 8'hBB},
      {1'b1, 1'b1, 8'h40, 16'h0002, 8'hAA}
   };

   // {line[7:0], be[15:0], data[127:0]} expected in leaving order
   localparam logic [151:0] POP_TAB [0:7] = '{
      {8'h10, 16'h000F, 128'h0000_0000_0000_0000_0000_0000_1111_1111},
      {8'h20, 16'h00F0, 128'h0000_0000_0000_0000_2222_4444_0000_0000},
      {8'h10, 16'hFF00, 128'h7777_7777_3333_3333_0000_0000_0000_0000},
      {8'h30, 16'h0001, 128'h0000_0000_0000_0000_0000_0000_0000_0055},
      {8'h30, 16'h0002, 128'h0000_0000_0000_0000_0000_0000_0000_6600},
      {8'h40, 16'h0001, 128'h0000_0000_0000_0000_0000_0000_0000_0088},
      {8'h40, 16'h0003, 128'h0000_0000_0000_0000_0000_0000_0000_AA99},
      {8'h50, 16'h0001, 128'h0000_0000_0000_0000_0000_0000_0000_00BB}
   };

   function automatic string pop_req(int i);
      case (i)
         0: return "R5 head kept";
         1: return "R3 merge";
         2: return "R3 merge/R5 new slot";
         3, 4: return "R4 no merge";
         5: return "R2 order";
         6: return "R2 R6 merge when full";
         default: return "R2 order";
      endcase
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input bit coal, input bit ok, input bit ub,
                        input logic [7:0] line, input logic [15:0] be, input logic [7:0] fill);
      coalesce_en = coal;
      st_merge_ok = ok;
      st_unbuf    = ub;
      st_line     = TAG_W'(line);
      st_be       = be;
      st_data     = {16{fill}};
      st_valid    = 1'b1;
   endtask

   task automatic push(input bit coal, input bit ok, input logic [7:0] line,
                       input logic [15:0] be, input logic [7:0] fill, output bit took);
      @(negedge clk);
      drive(coal, ok, 1'b0, line, be, fill);
      took = 1'b0;
      for (int n = 0; n < 20 && !took; n++) begin
         if (st_ready) took = 1'b1;
         else @(negedge clk);
      end
      if (took) @(posedge clk);
      #1 st_valid = 1'b0;
   endtask

   task automatic pop_chk(input string req, input logic [151:0] exp);
      logic [127:0] mask;
      @(negedge clk);
      for (int b = 0; b < LINE_B; b++) mask[b*8 +: 8] = {8{bus_be[b]}};
      check({req, " valid"}, 128'(bus_valid), 128'd1);
      check({req, " line"}, 128'(bus_line), 128'(exp[151:144]));
      check({req, " be"}, 128'(bus_be), 128'(exp[143:128]));
      check({req, " data"}, bus_data & mask, exp[127:0]);
      bus_ready = 1'b1;
      @(posedge clk);
      #1 bus_ready = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      bit took;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 st_ready", 128'(st_ready), 128'd1);
      check("R1 bus_valid", 128'(bus_valid), 128'd0);

      for (int i = 0; i < 11; i++) begin
         push(ST_TAB[i][33], ST_TAB[i][32], ST_TAB[i][31:24],
              ST_TAB[i][23:8], ST_TAB[i][7:0], took);
         check(i == 10 ? "R6 merge accepted when full" : "R2 store accepted",
               128'(took), 128'd1);
      end

      @(negedge clk);
      drive(1'b1, 1'b1, 1'b0, 8'h60, 16'h0001, 8'hEE);
      #1 check("R6 full stall", 128'(st_ready), 128'd0);
      drive(1'b0, 1'b1, 1'b0, 8'h40, 16'h0004, 8'hEE);
      #1 check("R6 full stall no merge", 128'(st_ready), 128'd0);
      st_valid = 1'b0;
      check("R9 head held line", 128'(bus_line), 128'h10);
      check("R9 head valid", 128'(bus_valid), 128'd1);

      for (int i = 0; i < 8; i++) pop_chk(pop_req(i), POP_TAB[i]);
      @(negedge clk);
      check("R2 empty after drain", 128'(bus_valid), 128'd0);

      // R7 unbuffered store
      push(1'b0, 1'b0, 8'h70, 16'h0001, 8'h70, took);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b1, 8'h71, 16'hFFFF, 8'hC1);
      repeat (3) @(negedge clk);
      check("R7 unbuf waits for empty", 128'(st_ready), 128'd0);
      pop_chk("R7 older first", {8'h70, 16'h0001, 128'h70});
      @(negedge clk);
      check("R7 unbuf accepted when empty", 128'(st_ready), 128'd1);
      @(posedge clk);
      #1 drive(1'b0, 1'b0, 1'b0, 8'h72, 16'h0001, 8'h72);
      @(negedge clk);
      check("R7 producer held", 128'(st_ready), 128'd0);
      @(negedge clk);
      check("R7 producer still held", 128'(st_ready), 128'd0);
      check("R7 unbuf at head", 128'(bus_line), 128'h71);
      bus_ready = 1'b1;
      @(posedge clk);
      #1 bus_ready = 1'b0;
      @(negedge clk);
      check("R7 released after completion", 128'(st_ready), 128'd1);
      @(posedge clk);
      #1 st_valid = 1'b0;
      pop_chk("R7 next store", {8'h72, 16'h0001, 128'h72});

      // R8 drain
      push(1'b0, 1'b0, 8'h80, 16'h0001, 8'h80, took);
      push(1'b0, 1'b0, 8'h81, 16'h0001, 8'h81, took);
      @(negedge clk);
      drain_req = 1'b1;
      @(negedge clk);
      drain_req = 1'b0;
      drive(1'b0, 1'b0, 1'b0, 8'h82, 16'h0001, 8'h82);
      #1 check("R8 blocked while draining", 128'(st_ready), 128'd0);
      pop_chk("R8 drain order", {8'h80, 16'h0001, 128'h80});
      pop_chk("R8 drain order", {8'h81, 16'h0001, 128'h81});
      @(negedge clk);
      check("R8 nothing slipped in", 128'(bus_valid), 128'd0);
      check("R8 blocked until empty seen", 128'(st_ready), 128'd0);
      @(negedge clk);
      check("R8 released after empty", 128'(st_ready), 128'd1);
      @(posedge clk);
      #1 st_valid = 1'b0;
      pop_chk("R8 store after drain", {8'h82, 16'h0001, 128'h82});

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule